// File: doc/BRIEF.md
# Two-Wire Serial Byte Transfer Controller

This block moves one byte at a time over a two-wire serial bus made of a shared open-drain data line and a serial clock line. Software starts a transfer only by writing the shift register. The controller then presents each outgoing bit most significant first after each clock falling edge, samples the line on each rising edge, and stops by itself after the last bit. At that point it stores the received byte and raises an interrupt flag. Because the data line is wired-AND, a byte of all ones lets the remote side's bits through unchanged. This is how a receive is done.

If the remote side holds the data line low to signal busy when the write arrives, the byte is kept. Shifting begins only after the line returns high. In wake-up mode the controller never pulls the line for shift data. The interrupt fires only when the first byte after a bus-release indication equals the programmed address. The controller can also drive its own busy level onto the line. After a release request, that level stays on until the next clock falling edge. The synchronised line level is exposed so software can confirm the line is high before changing modes.

Top module: `sbus_xfer`

## Requirements
- R1: After reset the line is not pulled, the interrupt flag and error flag are 0, and the read port returns 0.
- R2: A shift-register write made while the enable input is 0 is discarded. Raising the enable input later does not start a transfer: clock pulses then leave the line untouched, the interrupt flag stays 0 and the read port stays unchanged.
- R3: A write while enabled and idle starts a transfer. Bit 7 is driven first. Each bit appears on the line after an SCK falling edge, and a 0 bit pulls the line low.
- R4: The line is sampled on each SCK rising edge, first sample into bit 7. After the eighth rising edge the transfer stops, the read port returns the received byte (the wired-AND of both sides), and with wake-up off the interrupt flag is set.
- R5: A write made while the line is held low is retained. Clock pulses during that time shift nothing. Once the line reads high, the full byte transfers normally.
- R6: A write while a transfer is pending or active is ignored and sets a sticky error flag. The flag stays 1 until the error-clear input is pulsed. The running transfer is unaffected.
- R7: With wake-up on, the controller never pulls the line for shift data, whatever was written.
- R8: With wake-up on, the interrupt flag is set only when the first byte completed after a bus-release pulse equals the address input.
- R9: With wake-up on, a mismatching first byte leaves the interrupt flag 0. Later bytes also raise no interrupt until another bus-release pulse.
- R10: A busy-set pulse pulls the line low. After a busy-release pulse the line stays pulled until the next SCK falling edge, and is then released.
- R11: Turning wake-up on while busy is driven does not release the line.
- R12: The interrupt flag is cleared by an acknowledge pulse. The line-level output follows the synchronised data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Transfer enable |
| wake_i | input | 1 | Wake-up (address match) mode |
| wr_i | input | 1 | Shift-register write strobe |
| wdata_i | input | DATA_W | Byte to send |
| rdata_o | output | DATA_W | Last received byte |
| rel_i | input | 1 | Bus-release indication pulse |
| addr_i | input | DATA_W | Own slave address |
| busy_set_i | input | 1 | Start driving busy |
| busy_rel_i | input | 1 | Request busy release |
| irq_ack_i | input | 1 | Clear interrupt flag |
| err_clr_i | input | 1 | Clear error flag |
| sck_i | input | 1 | Serial clock line |
| sd_i | input | 1 | Data line level |
| sd_pull_o | output | 1 | Pull data line low |
| sd_level_o | output | 1 | Synchronised data line level |
| irq_o | output | 1 | Transfer interrupt flag |
| err_o | output | 1 | Sticky write-collision flag |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 3. The deeper synchroniser puts four cycles between a line edge and its effect. This still fits inside the bench's eight-cycle half clock period, so every bit sample and the busy-release point land in a known window. The byte width of eight keeps the address match a full-byte comparison, and wired-AND results can be checked against both sides' bytes.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } sbx_state_e;
endpackage

// File: rtl/sbx_sync.sv
module sbx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic [STAGES:0]   ext;

    always_comb begin
        ext     = {chain_q, d_i};
        chain_d = ext[STAGES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sbx_addr_match.sv
module sbx_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] byte_i,
    input  logic [W-1:0] addr_i,
    output logic         hit_o
);
    assign hit_o = (byte_i == addr_i);
endmodule

// File: rtl/sbus_xfer.sv
module sbus_xfer
    import sbx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wake_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              rel_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic              busy_set_i,
    input  logic              busy_rel_i,
    input  logic              irq_ack_i,
    input  logic              err_clr_i,
    input  logic              sck_i,
    input  logic              sd_i,
    output logic              sd_pull_o,
    output logic              sd_level_o,
    output logic              irq_o,
    output logic              err_o
);
    localparam int               CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        sbx_state_e        st;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rx;
        logic [CNT_W-1:0]  cnt;
        logic              out;
        logic              sck_prev;
        logic              busy;
        logic              relp;
        logic              armed;
        logic              irq;
        logic              err;
    } regs_t;

    regs_t q, d;
    logic  sck_s, sd_s, sck_fall, sck_rise, done, hit;
    logic [DATA_W-1:0] shifted;

    sbx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
    sbx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sd (
        .clk(clk), .rst_n(rst_n), .d_i(sd_i), .q_o(sd_s));

    assign sck_fall = q.sck_prev & ~sck_s;
    assign sck_rise = ~q.sck_prev & sck_s;
    assign shifted  = {q.sr[DATA_W-2:0], sd_s};

    sbx_addr_match #(.W(DATA_W)) u_match (
        .byte_i(shifted), .addr_i(addr_i), .hit_o(hit));

    always_comb begin
        d          = q;
        done       = 1'b0;
        d.sck_prev = sck_s;

        if (err_clr_i) d.err = 1'b0;

        // software write: start, hold for busy, or collision
        if (wr_i) begin
            if (q.st != ST_IDLE) begin
                d.err = 1'b1;
            end else if (en_i) begin
                d.sr  = wdata_i;
                d.out = 1'b1;
                d.cnt = '0;
                d.st  = sd_s ? ST_SHIFT : ST_WAIT;
            end
        end

        case (q.st)
            ST_WAIT: begin
                if (sd_s) d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sck_fall) d.out = q.sr[DATA_W-1];
                if (sck_rise) begin
                    d.sr  = shifted;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        done  = 1'b1;
                        d.st  = ST_IDLE;
                        d.rx  = shifted;
                        d.out = 1'b1;
                        d.cnt = '0;
                    end
                end
            end
            default: d.cnt = '0;
        endcase

        // interrupt flag: acknowledge, then completion sets
        if (irq_ack_i) d.irq = 1'b0;
        if (done) begin
            if (!wake_i)              d.irq = 1'b1;
            else if (q.armed && hit)  d.irq = 1'b1;
        end
        d.armed = (q.armed & ~done) | rel_i;

        // busy drive: release waits for the next clock fall
        if (busy_rel_i) d.relp = 1'b1;
        if (sck_fall && q.relp) begin
            d.busy = 1'b0;
            d.relp = 1'b0;
        end
        if (busy_set_i) begin
            d.busy = 1'b1;
            d.relp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.out      <= 1'b1;
            q.sck_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sd_pull_o  = q.busy | (~wake_i & (q.st == ST_SHIFT) & ~q.out);
    assign sd_level_o = sd_s;
    assign rdata_o    = q.rx;
    assign irq_o      = q.irq;
    assign err_o      = q.err;

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (q.cnt == '0)); // R3
    AST_IRQ_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(q.st == ST_SHIFT)); // R4
    AST_WAIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && !sd_s) |=> (q.st == ST_WAIT)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o); // R6
    AST_WAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $past(wake_i)) |-> $past(hit && q.armed)); // R8
    AST_BUSY_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(sck_fall)); // R10
endmodule

// File: tb/sbus_xfer_tb.sv
module sbus_xfer_tb;
    localparam int CLK_PER = 10;
    localparam int H       = 8;
    localparam logic [7:0] ADDR = 8'h6B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, wake = 0, wr = 0, rel = 0, bset = 0, brel = 0, ack = 0, eclr = 0;
    logic sck = 1'b1, slave_low = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic pull, level, irq, err, line;

    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0] rx;
        logic       irq;
        logic [7:0] seen;
    } item_t;
    item_t exp_q[$];
    item_t obs_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;
    assign line = !(pull || slave_low);

    sbus_xfer #(.DATA_W(8), .SYNC_STAGES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .wake_i(wake), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .rel_i(rel), .addr_i(ADDR),
        .busy_set_i(bset), .busy_rel_i(brel), .irq_ack_i(ack), .err_clr_i(eclr),
        .sck_i(sck), .sd_i(line), .sd_pull_o(pull), .sd_level_o(level),
        .irq_o(irq), .err_o(err));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic write(input logic [7:0] v);
        @(negedge clk) begin wr = 1'b1; wdata = v; end
        @(negedge clk) wr = 1'b0;
    endtask

    task automatic sck_pulse();
        sck = 1'b0;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic run_byte(input logic [7:0] stx, output logic [7:0] seen);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            slave_low = !stx[i];
            repeat (H) @(negedge clk);
            seen[i] = line;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
        slave_low = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    // driver: pushes expectation, runs the byte, hands observation to monitor
    task automatic xfer(input logic [7:0] tx, input logic [7:0] stx,
                        input logic exp_irq, input string tag);
        item_t e, o;
        logic [7:0] seen;
        e.rx   = wake ? stx : (tx & stx);
        e.seen = e.rx;
        e.irq  = exp_irq;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        write(tx);
        run_byte(stx, seen);
        o.rx = rdata; o.irq = irq; o.seen = seen;
        obs_q.push_back(o);
        repeat (2) @(negedge clk);
        pulse(ack);
    endtask

    initial begin : monitor
        item_t e, o;
        string t;
        forever begin
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(o.seen == e.seen, {t, " line bits"}, 32'(o.seen), 32'(e.seen));
            check(o.rx == e.rx, {t, " rdata"}, 32'(o.rx), 32'(e.rx));
            check(o.irq == e.irq, {t, " irq"}, 32'(o.irq), 32'(e.irq));
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(pull == 0, "R1 pull", 32'(pull), 0);
        check(irq == 0, "R1 irq", 32'(irq), 0);
        check(err == 0, "R1 err", 32'(err), 0);
        check(rdata == 0, "R1 rdata", 32'(rdata), 0);

        // R2 write while disabled, then enable: nothing runs
        write(8'h5A);
        en = 1'b1;
        run_byte(8'hFF, seen);
        check(seen == 8'hFF, "R2 line untouched", 32'(seen), 32'hFF);
        check(irq == 0, "R2 irq", 32'(irq), 0);
        check(rdata == 0, "R2 rdata", 32'(rdata), 0);

        // R3 / R4 send, receive, wired-AND; R12 ack
        xfer(8'hA5, 8'hFF, 1'b1, "R3 send");
        check(irq == 0, "R12 ack clears", 32'(irq), 0);
        xfer(8'hFF, 8'h3C, 1'b1, "R4 receive");
        xfer(8'hC3, 8'h0F, 1'b1, "R4 wired-and");

        // R5 busy hold
        slave_low = 1'b1;
        repeat (H) @(negedge clk);
        check(level == 0, "R12 level low", 32'(level), 0);
        exp_q.push_back('{rx: 8'h96, irq: 1'b1, seen: 8'h96});
        tag_q.push_back("R5 held byte");
        write(8'h96);
        sck_pulse(); sck_pulse(); sck_pulse();
        check(irq == 0, "R5 no shift while busy", 32'(irq), 0);
        slave_low = 1'b0;
        repeat (H) @(negedge clk);
        check(level == 1, "R12 level high", 32'(level), 1);
        run_byte(8'hFF, seen);
        obs_q.push_back('{rx: rdata, irq: irq, seen: seen});
        repeat (2) @(negedge clk);
        pulse(ack);

        // R6 collision write
        exp_q.push_back('{rx: 8'h81, irq: 1'b1, seen: 8'h81});
        tag_q.push_back("R6 transfer intact");
        write(8'h81);
        write(8'h00);
        check(err == 1, "R6 err set", 32'(err), 1);
        run_byte(8'hFF, seen);
        obs_q.push_back('{rx: rdata, irq: irq, seen: seen});
        check(err == 1, "R6 err sticky", 32'(err), 1);
        pulse(eclr);
        check(err == 0, "R6 err cleared", 32'(err), 0);
        pulse(ack);

        // R7 / R8 / R9 wake-up mode
        wake = 1'b1;
        xfer(8'h00, 8'hFF, 1'b0, "R7 no drive");
        pulse(rel);
        xfer(8'h00, ADDR, 1'b1, "R8 match");
        pulse(rel);
        xfer(8'h00, 8'h12, 1'b0, "R9 mismatch");
        xfer(8'h00, ADDR, 1'b0, "R9 not re-armed");

        // R10 busy release timing
        wake = 1'b0;
        pulse(bset);
        check(pull == 1, "R10 busy drives", 32'(pull), 1);
        pulse(brel);
        repeat (H) @(negedge clk);
        check(pull == 1, "R10 held until fall", 32'(pull), 1);
        sck = 1'b0;
        repeat (H) @(negedge clk);
        check(pull == 0, "R10 released after fall", 32'(pull), 0);
        sck = 1'b1;
        repeat (H) @(negedge clk);

        // R11 wake-up set during busy
        pulse(bset);
        wake = 1'b1;
        repeat (H) @(negedge clk);
        check(pull == 1, "R11 busy kept", 32'(pull), 1);
        pulse(brel);
        sck_pulse();
        check(pull == 0, "R11 released by fall", 32'(pull), 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule